// File: doc/BRIEF.md
# Condition Code Register with Per-Lane Write Enables

This block holds a four-lane condition-code register for a vector shader datapath and turns an instruction's static destination mask into the final per-lane write enables. When an update is requested, each 32-bit IEEE-754 lane of the result is sorted into one of four classes: negative, zero, positive, or unordered (NaN). The class is stored in the matching condition lane. Only the lanes selected by the instruction's static mask are stored.

On the write side, the caller gives a static xyzw mask, one of eight comparison rules and a per-lane selector. The selector picks which stored condition lane each destination lane tests, so a single condition lane can be broadcast to every destination lane. A lane is enabled when its static mask bit is set and its selected code meets the rule. An update-only instruction changes the codes and enables no lane. The enables always come from the codes held before the current clock edge.

Top module: `cc_mask_unit`

## Requirements
- R1: While reset is asserted, and at its release, every condition lane holds the zero code, so `cc_q` reads 8'h00.
- R2: Codes are two bits per lane, with lane i at `cc_q[2i+1:2i]`: 00 zero, 01 negative, 10 positive, 11 unordered. Both signed zeros store 00. Infinities and nonzero finite values (subnormals included) store 01 when the sign bit is set and 10 when it is clear.
- R3: A lane whose exponent field is all ones and whose mantissa is nonzero (NaN) stores 11, whatever its sign.
- R4: On a clock edge with `upd_en` high, only the lanes whose `upd_mask` bit is set take new codes. With `upd_en` low, no lane changes.
- R5: `wr_en` and `cc_q` in a cycle that carries an update reflect the codes stored before that update. The new codes appear after the clock edge.
- R6: Rule encoding on `wr_rule`: 0 never, 1 less, 2 equal, 3 less-or-equal, 4 greater, 5 not-equal, 6 greater-or-equal, 7 always. For ordered codes, bit 0 accepts negative, bit 1 accepts zero and bit 2 accepts positive.
- R7: An unordered code meets only the not-equal (5) and always (7) rules.
- R8: Destination lane i tests the stored code of condition lane `wr_swz[2i+1:2i]`. Repeating one index broadcasts that condition lane.
- R9: `wr_en[i]` equals `wr_mask[i]` ANDed with the rule result for lane i's selected code.
- R10: With `cc_only` high, `wr_en` is 0000. An update requested in the same cycle still takes effect.
- R11: Rule 0 yields `wr_en` of 0000, and rule 7 yields `wr_en` equal to `wr_mask` (with `cc_only` low), whatever the stored codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_en | input | 1 | Store new condition codes at this edge |
| upd_mask | input | 4 | Static xyzw mask; limits which condition lanes are stored |
| upd_data | input | 128 | Four 32-bit float result lanes, lane i at [32i+31:32i] |
| cc_only | input | 1 | Update-only instruction: no destination lane is enabled |
| wr_mask | input | 4 | Static destination write mask |
| wr_rule | input | 3 | Comparison rule applied to the selected codes |
| wr_swz | input | 8 | Condition lane selector, two bits per destination lane |
| wr_en | output | 4 | Final per-lane write enables |
| cc_q | output | 8 | Stored condition codes, two bits per lane |

## Verification
A wrong stored code is visible at `cc_q` one edge after the update that produced it. It is also visible at `wr_en` in any later cycle whose selector picks that lane under a rule that separates the classes. A lane that is updated when it is masked off, or that keeps a stale value, shows on `cc_q` at the next edge. A bypass of the new codes into `wr_en` shows in the update cycle itself, before the edge. A fault in the rule or selector logic is combinational, so it appears at `wr_en` in the same cycle as the stimulus.

// File: rtl/cc_pkg.sv
package cc_pkg;

   localparam int CODE_W = 2;
   localparam int RULE_W = 3;

   typedef enum logic [CODE_W-1:0] {
      CC_ZERO = 2'b00,
      CC_NEG  = 2'b01,
      CC_POS  = 2'b10,
      CC_UNORD = 2'b11
   } cc_code_e;

   // Each ordered rule is the set of accepted ordered classes:
   // bit0 accepts negative, bit1 accepts zero, bit2 accepts positive.
   typedef enum logic [RULE_W-1:0] {
      RULE_NEVER = 3'd0,
      RULE_LESS  = 3'd1,
      RULE_EQUAL = 3'd2,
      RULE_LEQ   = 3'd3,
      RULE_GREAT = 3'd4,
      RULE_NEQ   = 3'd5,
      RULE_GEQ   = 3'd6,
      RULE_ALWAYS = 3'd7
   } cc_rule_e;

endpackage

// File: rtl/cc_classify.sv
module cc_classify
   import cc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int EXP_W  = 8,
   parameter int MAN_W  = 23
) (
   input  logic [DATA_W-1:0] value,
   output logic [CODE_W-1:0] code
);

   localparam int SIGN_BIT = DATA_W - 1;

   logic             sign;
   logic [EXP_W-1:0] expo;
   logic [MAN_W-1:0] mant;
   logic             exp_max;
   logic             exp_zero;
   logic             man_zero;

   assign sign     = value[SIGN_BIT];
   assign expo     = value[MAN_W +: EXP_W];
   assign mant     = value[MAN_W-1:0];
   assign exp_max  = &expo;
   assign exp_zero = ~|expo;
   assign man_zero = ~|mant;

   always_comb begin
      if (exp_max && !man_zero)
         code = CC_UNORD;
      else if (exp_zero && man_zero)
         code = CC_ZERO;
      else if (sign)
         code = CC_NEG;
      else
         code = CC_POS;
   end

endmodule

// File: rtl/cc_store.sv
module cc_store
   import cc_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [LANES-1:0]         ld,
   input  logic [LANES*CODE_W-1:0]  d,
   output logic [LANES*CODE_W-1:0]  q
);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q[i*CODE_W +: CODE_W] <= CC_ZERO;
         else if (ld[i])
            q[i*CODE_W +: CODE_W] <= d[i*CODE_W +: CODE_W];
      end
   end

endmodule

// File: rtl/cc_rule_eval.sv
module cc_rule_eval
   import cc_pkg::*;
(
   input  logic [CODE_W-1:0] code,
   input  logic [RULE_W-1:0] rule,
   output logic              pass
);

   always_comb begin
      case (code)
         CC_NEG:  pass = rule[0];
         CC_ZERO: pass = rule[1];
         CC_POS:  pass = rule[2];
         default: pass = (rule == RULE_NEQ) || (rule == RULE_ALWAYS);
      endcase
   end

endmodule

// File: rtl/cc_mask_unit.sv
module cc_mask_unit
   import cc_pkg::*;
#(
   parameter int LANES      = 4,
   parameter int DATA_W     = 32,
   parameter int EXP_W      = 8,
   parameter int MAN_W      = 23,
   parameter bit SWIZZLE_EN = 1'b1,
   localparam int SEL_W     = $clog2(LANES),
   localparam int CC_W      = LANES * CODE_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    upd_en,
   input  logic [LANES-1:0]        upd_mask,
   input  logic [LANES*DATA_W-1:0] upd_data,
   input  logic                    cc_only,
   input  logic [LANES-1:0]        wr_mask,
   input  logic [RULE_W-1:0]       wr_rule,
   input  logic [LANES*SEL_W-1:0]  wr_swz,
   output logic [LANES-1:0]        wr_en,
   output logic [CC_W-1:0]         cc_q
);

   // Elaboration-time parameter checks
   if (DATA_W != 1 + EXP_W + MAN_W) begin : g_bad_fmt
      $error("cc_mask_unit: DATA_W must equal 1 + EXP_W + MAN_W");
   end
   if (LANES < 2 || (1 << SEL_W) != LANES) begin : g_bad_lanes
      $error("cc_mask_unit: LANES must be a power of two, at least 2");
   end

   logic [CC_W-1:0]  new_codes;
   logic [LANES-1:0] load;
   logic [CC_W-1:0]  sel_codes;
   logic [LANES-1:0] rule_pass;

   // Per-lane classification of the incoming result
   for (genvar i = 0; i < LANES; i++) begin : g_cls
      cc_classify #(
         .DATA_W (DATA_W),
         .EXP_W  (EXP_W),
         .MAN_W  (MAN_W)
      ) u_cls (
         .value (upd_data[i*DATA_W +: DATA_W]),
         .code  (new_codes[i*CODE_W +: CODE_W])
      );
   end

   assign load = upd_en ? upd_mask : '0;

   cc_store #(.LANES(LANES)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (load),
      .d     (new_codes),
      .q     (cc_q)
   );

   // Condition lane selection: full crossbar or fixed identity
   if (SWIZZLE_EN) begin : g_swz
      for (genvar i = 0; i < LANES; i++) begin : g_sel
         logic [SEL_W-1:0] idx;
         assign idx = wr_swz[i*SEL_W +: SEL_W];
         assign sel_codes[i*CODE_W +: CODE_W] = cc_q[idx*CODE_W +: CODE_W];
      end
   end else begin : g_ident
      logic unused_swz;
      assign unused_swz = ^wr_swz;
      assign sel_codes  = cc_q;
   end

   for (genvar i = 0; i < LANES; i++) begin : g_rule
      cc_rule_eval u_eval (
         .code (sel_codes[i*CODE_W +: CODE_W]),
         .rule (wr_rule),
         .pass (rule_pass[i])
      );
   end

   assign wr_en = cc_only ? '0 : (wr_mask & rule_pass);

endmodule

// File: rtl/cc_mask_chk.sv
module cc_mask_chk
   import cc_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int DATA_W = 32,
   parameter int EXP_W  = 8,
   parameter int MAN_W  = 23,
   localparam int CC_W  = LANES * CODE_W
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    upd_en,
   input logic [LANES-1:0]        upd_mask,
   input logic [LANES*DATA_W-1:0] upd_data,
   input logic                    cc_only,
   input logic [LANES-1:0]        wr_mask,
   input logic [RULE_W-1:0]       wr_rule,
   input logic [LANES-1:0]        wr_en,
   input logic [CC_W-1:0]         cc_q
);

   // R1: reset leaves every lane at the zero code
   p_reset_zero_r1: assert property (@(posedge clk)
      !rst_n |=> cc_q == '0);

   // R9: no lane is enabled outside the static mask
   p_en_in_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en & ~wr_mask) == '0);

   // R10: update-only form enables nothing
   p_cc_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cc_only |-> wr_en == '0);

   // R11: never rule enables nothing
   p_never_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_rule == RULE_NEVER |-> wr_en == '0);

   // R11: always rule follows the static mask
   p_always_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_rule == RULE_ALWAYS && !cc_only) |-> wr_en == wr_mask);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [DATA_W-1:0] v;
      logic              is_nan;
      assign v      = upd_data[i*DATA_W +: DATA_W];
      assign is_nan = (&v[MAN_W +: EXP_W]) && (|v[MAN_W-1:0]);

      // R4: a lane not selected for update holds its code
      p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
         !(upd_en && upd_mask[i]) |=> $stable(cc_q[i*CODE_W +: CODE_W]));

      // R3: a stored NaN lane reads unordered
      p_nan_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (upd_en && upd_mask[i] && is_nan) |=> cc_q[i*CODE_W +: CODE_W] == CC_UNORD);
   end

endmodule

bind cc_mask_unit cc_mask_chk #(
   .LANES  (LANES),
   .DATA_W (DATA_W),
   .EXP_W  (EXP_W),
   .MAN_W  (MAN_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .upd_en   (upd_en),
   .upd_mask (upd_mask),
   .upd_data (upd_data),
   .cc_only  (cc_only),
   .wr_mask  (wr_mask),
   .wr_rule  (wr_rule),
   .wr_en    (wr_en),
   .cc_q     (cc_q)
);

// File: tb/sim_cc_mask_unit.sv
`timescale 1ns/1ps
module sim_cc_mask_unit;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         upd_en = 1'b0;
   logic [3:0]   upd_mask = '0;
   logic [127:0] upd_data = '0;
   logic         cc_only = 1'b0;
   logic [3:0]   wr_mask = '0;
   logic [2:0]   wr_rule = '0;
   logic [7:0]   wr_swz = 8'b11_10_01_00;
   logic [3:0]   wr_en;
   logic [7:0]   cc_q;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   logic [1:0] model [4];

   always #5 clk = ~clk;

   cc_mask_unit u0 (
      .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_mask(upd_mask),
      .upd_data(upd_data), .cc_only(cc_only), .wr_mask(wr_mask),
      .wr_rule(wr_rule), .wr_swz(wr_swz), .wr_en(wr_en), .cc_q(cc_q)
   );

   localparam logic [31:0] P_ONE = 32'h3F80_0000;
   localparam logic [31:0] N_ZER = 32'h8000_0000;
   localparam logic [31:0] N_INF = 32'hFF80_0000;
   localparam logic [31:0] P_INF = 32'h7F80_0000;
   localparam logic [31:0] Q_NAN = 32'h7FC0_0000;

   // R2/R3 encoding: 00 zero, 01 negative, 10 positive, 11 unordered
   function automatic logic [1:0] classify(input logic [31:0] v);
      if (v[30:23] == 8'hFF && v[22:0] != 0) return 2'b11;
      if (v[30:0] == 0) return 2'b00;
      return v[31] ? 2'b01 : 2'b10;
   endfunction

   // R6/R7 rule semantics
   function automatic bit rule_ok(input logic [1:0] c, input logic [2:0] r);
      case (c)
         2'b01: return r == 3'd1 || r == 3'd3 || r == 3'd5 || r == 3'd7;
         2'b00: return r == 3'd2 || r == 3'd3 || r == 3'd6 || r == 3'd7;
         2'b10: return r == 3'd4 || r == 3'd5 || r == 3'd6 || r == 3'd7;
         default: return r == 3'd5 || r == 3'd7;
      endcase
   endfunction

   function automatic logic [3:0] exp_en();
      logic [3:0] e;
      for (int i = 0; i < 4; i++)
         e[i] = wr_mask[i] && !cc_only && rule_ok(model[wr_swz[2*i +: 2]], wr_rule);
      return e;
   endfunction

   function automatic logic [7:0] exp_cc();
      return {model[3], model[2], model[1], model[0]};
   endfunction

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // One cycle: drive at negedge, check combinational enables and stored
   // codes before the edge, then advance the model past the edge.
   task automatic step(input bit ue, input logic [3:0] um, input logic [127:0] ud,
                       input bit co, input logic [3:0] wm, input logic [2:0] wr,
                       input logic [7:0] sw, input string req_en, input string req_cc);
      @(negedge clk);
      upd_en = ue; upd_mask = um; upd_data = ud; cc_only = co;
      wr_mask = wm; wr_rule = wr; wr_swz = sw;
      #1;
      check({4'b0, wr_en}, {4'b0, exp_en()}, req_en);
      check(cc_q, exp_cc(), req_cc);
      @(posedge clk);
      #1;
      if (ue) for (int i = 0; i < 4; i++)
         if (um[i]) model[i] = classify(ud[32*i +: 32]);
   endtask

   function automatic logic [31:0] pick_val();
      case ($urandom_range(0, 7))
         0: return 32'h0;
         1: return N_ZER;
         2: return P_INF;
         3: return N_INF;
         4: return Q_NAN | {$urandom_range(0, 1), 31'h0};
         5: return {1'b0, 8'hFF, 23'h1};
         6: return {$urandom_range(0, 1), 8'h00, 23'h5};
         default: return $urandom();
      endcase
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      for (int i = 0; i < 4; i++) model[i] = 2'b00;
      repeat (2) @(posedge clk);
      #1 check(cc_q, 8'h00, "R1 in reset");
      @(negedge clk) rst_n = 1'b1;
      #1 check(cc_q, 8'h00, "R1 after release");

      // R2/R3 classification; R5 enables use old codes (all zero) under rule equal
      step(1, 4'b1111, {Q_NAN, N_INF, N_ZER, P_ONE}, 0, 4'b1111, 3'd2, 8'b11_10_01_00,
           "R5 old codes", "R1");
      step(0, 4'b0000, '0, 0, 4'b1111, 3'd7, 8'b11_10_01_00, "R11 always", "R2 R3 classes");
      // R4 partial update: lanes x and z to +inf
      step(1, 4'b0101, {4{P_INF}}, 0, 4'b1111, 3'd0, 8'b11_10_01_00, "R11 never", "R2");
      step(1, 4'b1111, {4{32'h0}}, 0, 4'b0000, 3'd7, 8'b11_10_01_00, "R9 empty mask", "R4 mask");
      step(0, 4'b1111, {4{P_ONE}}, 0, 4'b0000, 3'd7, 8'b11_10_01_00, "R9", "R4 all lanes");
      // reload known codes: x GT, y EQ, z GT, w UN
      step(1, 4'b1111, {Q_NAN, P_INF, N_ZER, P_ONE}, 0, 4'b0000, 3'd0, 8'h00, "R9", "R4");
      // R8: not-equal on broadcast z, mask xy
      step(0, 4'b0000, '0, 0, 4'b0011, 3'd5, 8'b10_10_10_10, "R8 NE.z", "R4 disabled upd");
      step(1, 4'b0100, {4{N_ZER}}, 0, 4'b0011, 3'd5, 8'b10_10_10_10, "R8 R5 NE.z old", "R4");
      step(0, 4'b0000, '0, 0, 4'b0011, 3'd5, 8'b10_10_10_10, "R8 NE.z zero", "R2 neg zero");
      // R7: unordered broadcast under each rule
      for (int r = 0; r < 8; r++)
         step(0, 4'b0000, '0, 0, 4'b1111, 3'(r), 8'hFF, "R7 unordered", "R4");
      // R6: distinct swizzle, each rule
      for (int r = 0; r < 8; r++)
         step(0, 4'b0000, '0, 0, 4'b1111, 3'(r), 8'b00_01_10_11, "R6 rules", "R4");
      // R10: update-only form still updates
      step(1, 4'b1111, {N_INF, N_INF, N_INF, N_INF}, 1, 4'b1111, 3'd7, 8'b11_10_01_00,
           "R10 cc_only", "R4");
      step(0, 4'b0000, '0, 0, 4'b1111, 3'd1, 8'b11_10_01_00, "R10 codes updated", "R10");

      for (int n = 0; n < 600; n++) begin
         logic [127:0] d;
         for (int i = 0; i < 4; i++) d[32*i +: 32] = pick_val();
         step(1'($urandom_range(0, 1)), 4'($urandom), d, ($urandom_range(0, 7) == 0),
              4'($urandom), 3'($urandom), 8'($urandom), "R9 random", "R2 R4 random");
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule